// File: doc/BRIEF.md
# Serial EEPROM Slave (64 x 16)

This block models a small serial non-volatile memory that a host reaches over four wires: chip select, serial clock, data in and a tri-state data out. The memory holds 64 words of 16 bits in a register array. The whole block runs on one system clock. It looks for rising edges of the serial clock in that domain, so the serial inputs are expected to be synchronous to the system clock already, and each serial clock phase must last at least one system clock.

A command begins with a start bit. A 2-bit operation code and a 6-bit word address follow, most significant bit first. Writes and fills then carry 16 data bits. Reads stream words out one after another and advance the address after each word. Every store operation is guarded twice: it needs a write-enable latch that software sets and clears, and it needs an exact count of serial clocks. The store begins when chip select falls. A parameter sets the programming time in system clocks. If chip select is raised while a store is in progress, the data output reports busy or ready.

Top module: `ser_eeprom_slave`

## Requirements
- R1: After reset the write-enable latch is clear and every word reads as all ones. The output enable stays low with chip select high until a start bit and address have been received.
- R2: While chip select is low the output enable is low, and serial clock and data-in activity has no effect on any later command.
- R3: Before the start bit, rising serial clock edges with data-in low are ignored. The first rising edge with data-in high is the start bit.
- R4: The frame is start bit, 2-bit code (10 read, 01 write, 11 erase, 00 special) and 6 address bits, MSB first. For a read, the edge that takes the last address bit drives the output to 0. Each later rising edge then presents one bit, D15 first.
- R5: A read that keeps clocking after D0 moves on to the next address, and address 63 is followed by address 0.
- R6: A write takes 16 data bits, MSB first, after the address. It is stored when chip select falls, but only if the write-enable latch is set.
- R7: With code 00, the top two address bits select a special command: 11 sets the write-enable latch and 00 clears it, both when chip select falls. While the latch is clear, write, erase, fill and clear-all change nothing.
- R8: Erase (11) sets the addressed word to all ones. Special 10 sets every word to all ones.
- R9: Special 01 writes the 16 data bits that follow the address into every word.
- R10: A store operation runs only if exactly 24 rising edges follow the start bit (write, fill) or exactly 8 follow it (erase, clear-all). Any other count cancels it.
- R11: After a store starts, raising chip select enables the output. The output is low while busy and high once done. Serial clock and data-in are ignored while busy.
- R12: While the ready level is shown, a rising edge with data-in high is taken as a new start bit. The output is released on the next system clock and the new frame is decoded as usual.
- R13: A store finishes WRITE_CYCLES system clocks after the clock edge that first sees chip select low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csIn | input | 1 | Chip select, active high |
| skIn | input | 1 | Serial clock, sampled on system clock |
| diIn | input | 1 | Serial data into the device |
| doOut | output | 1 | Serial data / status level out |
| doEn | output | 1 | Output enable for the tri-state data pin |

## Verification
The hardest condition to reach from the ports is a serial clock edge with data-in high that arrives while a store is still busy. The stimulus has to raise chip select during the programming window and pulse the clock inside that window, and the bench must also time the first ready level to the exact system clock. The bench closes chip select on a write, counts system clocks from that point, reopens select two clocks later and injects the high-data pulse on the fourth clock. It then checks that the ready level still appears at exactly WRITE_CYCLES+1 clocks. A second sequence keeps select high past ready, sends a start bit at once and runs a read through that same status phase.

// File: rtl/ser_eeprom_pkg.sv
package ser_eeprom_pkg;

  typedef enum logic [1:0] {
    OP_SPECIAL = 2'b00,
    OP_WRITE   = 2'b01,
    OP_READ    = 2'b10,
    OP_ERASE   = 2'b11
  } opcode_t;

  // sub-command carried in the two top address bits of code 00
  typedef enum logic [1:0] {
    SUB_LOCK   = 2'b00,
    SUB_FILL   = 2'b01,
    SUB_WIPE   = 2'b10,
    SUB_UNLOCK = 2'b11
  } subcmd_t;

  typedef enum logic [2:0] {
    ST_STBY,
    ST_HUNT,
    ST_HDR,
    ST_TAIL,
    ST_RD,
    ST_VERIFY
  } state_t;

  typedef struct packed {
    logic shiftHdr;
    logic shiftData;
    logic loadRead;
    logic shiftRead;
    logic progWord;
    logic clearWord;
    logic progAll;
    logic clearAll;
  } strobe_t;

endpackage

// File: rtl/ser_eeprom_ctrl.sv
module ser_eeprom_ctrl
  import ser_eeprom_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int DATA_W       = 16,
  parameter int WRITE_CYCLES = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csIn,
  input  logic       skIn,
  input  logic       diIn,
  input  logic [1:0] subCmd,
  input  logic       rdBit,
  output strobe_t    str,
  output logic       doOut,
  output logic       doEn
);

  localparam int HDR_LEN  = ADDR_W + 2;
  localparam int FULL_LEN = HDR_LEN + DATA_W;
  localparam int CNT_W    = $clog2(FULL_LEN + 2);
  localparam int TMR_W    = $clog2(WRITE_CYCLES + 1) < 1 ? 1 : $clog2(WRITE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  state_t           state;
  opcode_t          opReg;
  logic             csPrev, skPrev;
  logic [CNT_W-1:0] bitCnt;
  logic [TMR_W-1:0] busyCnt;
  logic             welQ, armed;

  logic skRise, csFall, busy, lastHdr, cntIsHdr, cntIsFull;
  logic wantProg, wantClear, wantFill, wantWipe, setWel, clrWel, launch;
  subcmd_t sub;

  always_comb begin
    skRise    = csIn & skIn & ~skPrev;
    csFall    = csPrev & ~csIn;
    busy      = (busyCnt != '0);
    lastHdr   = (bitCnt == CNT_W'(HDR_LEN - 1));
    cntIsHdr  = (bitCnt == CNT_W'(HDR_LEN));
    cntIsFull = (bitCnt == CNT_W'(FULL_LEN));
    sub       = subcmd_t'(subCmd);
    wantProg  = 1'b0;
    wantClear = 1'b0;
    wantFill  = 1'b0;
    wantWipe  = 1'b0;
    setWel    = 1'b0;
    clrWel    = 1'b0;
    if (state == ST_TAIL && csFall) begin
      case (opReg)
        OP_WRITE: wantProg  = cntIsFull;
        OP_ERASE: wantClear = cntIsHdr;
        OP_SPECIAL: begin
          case (sub)
            SUB_FILL:   wantFill = cntIsFull;
            SUB_WIPE:   wantWipe = cntIsHdr;
            SUB_UNLOCK: setWel   = 1'b1;
            default:    clrWel   = 1'b1;
          endcase
        end
        default: ;
      endcase
    end
    str.progWord  = wantProg  & welQ;
    str.clearWord = wantClear & welQ;
    str.progAll   = wantFill  & welQ;
    str.clearAll  = wantWipe  & welQ;
    launch        = str.progWord | str.clearWord | str.progAll | str.clearAll;
    str.shiftHdr  = (state == ST_HDR) & skRise;
    str.shiftData = (state == ST_TAIL) & skRise & (bitCnt < CNT_W'(FULL_LEN));
    str.loadRead  = (state == ST_HDR) & skRise & lastHdr & (opReg == OP_READ);
    str.shiftRead = (state == ST_RD) & skRise;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_STBY;
      opReg   <= OP_SPECIAL;
      csPrev  <= 1'b0;
      skPrev  <= 1'b0;
      bitCnt  <= '0;
      busyCnt <= '0;
      welQ    <= 1'b0;
      armed   <= 1'b0;
    end else begin
      csPrev <= csIn;
      skPrev <= skIn;
      if (busy) busyCnt <= busyCnt - TMR_W'(1);
      if (launch) begin
        busyCnt <= TMR_W'(WRITE_CYCLES);
        armed   <= 1'b1;
      end
      if (setWel) welQ <= 1'b1;
      if (clrWel) welQ <= 1'b0;
      if (!csIn) begin
        state <= ST_STBY;
      end else begin
        case (state)
          ST_STBY: state <= armed ? ST_VERIFY : ST_HUNT;
          ST_HUNT: begin
            if (skRise && diIn) begin
              state  <= ST_HDR;
              bitCnt <= '0;
            end
          end
          ST_VERIFY: begin
            if (!busy && skRise && diIn) begin
              state  <= ST_HDR;
              bitCnt <= '0;
              armed  <= 1'b0;
            end
          end
          ST_HDR: begin
            if (skRise) begin
              bitCnt <= bitCnt + CNT_W'(1);
              if (bitCnt < CNT_W'(2)) opReg <= opcode_t'({opReg[0], diIn});
              if (lastHdr) state <= (opReg == OP_READ) ? ST_RD : ST_TAIL;
            end
          end
          ST_TAIL: begin
            if (skRise && bitCnt != CNT_MAX) bitCnt <= bitCnt + CNT_W'(1);
          end
          default: ;
        endcase
      end
    end
  end

  assign doEn  = csIn & ((state == ST_RD) | (state == ST_VERIFY));
  assign doOut = (state == ST_RD) ? rdBit : ~busy;

  AST_LAUNCH_ON_CS_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (str.progWord || str.clearWord || str.progAll || str.clearAll) |-> ($fell(csIn) && welQ)); // R6
  AST_LATCH_ONLY_ON_CS_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !(csPrev && !csIn) |=> $stable(welQ)); // R7
  AST_BUSY_HOLDS_VERIFY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && state == ST_VERIFY) |=> (state == ST_VERIFY || state == ST_STBY)); // R11
  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busyCnt == $past(busyCnt) - TMR_W'(1))); // R13
  AST_START_RELEASES_DO: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_VERIFY && !busy && skRise && diIn) |=> !doEn); // R12
  AST_STANDBY_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    !csIn |=> (state == ST_STBY)); // R2

endmodule

// File: rtl/ser_eeprom_dpath.sv
module ser_eeprom_dpath
  import ser_eeprom_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       diIn,
  input  strobe_t    str,
  output logic [1:0] subCmd,
  output logic       rdBit
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int BITS_W = $clog2(DATA_W);
  localparam logic [BITS_W-1:0] LAST_BIT = BITS_W'(DATA_W - 1);

  logic [ADDR_W-1:0] hdrSh, newHdr, rdAddr, nextAddr;
  logic [DATA_W-1:0] dataSh, rdSh;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [BITS_W-1:0] rdCnt;
  logic [DEPTH-1:0]  hitProg, hitClear;

  assign newHdr   = {hdrSh[ADDR_W-2:0], diIn};
  assign nextAddr = rdAddr + ADDR_W'(1);
  assign subCmd   = hdrSh[ADDR_W-1 -: 2];

  for (genvar w = 0; w < DEPTH; w++) begin : g_hit
    assign hitProg[w]  = str.progAll  | (str.progWord  & (hdrSh == ADDR_W'(w)));
    assign hitClear[w] = str.clearAll | (str.clearWord & (hdrSh == ADDR_W'(w)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrSh  <= '0;
      dataSh <= '0;
    end else begin
      if (str.shiftHdr)  hdrSh  <= newHdr;
      if (str.shiftData) dataSh <= {dataSh[DATA_W-2:0], diIn};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '1;
    end else begin
      for (int w = 0; w < DEPTH; w++) begin
        if (hitProg[w])       mem[w] <= dataSh;
        else if (hitClear[w]) mem[w] <= '1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdAddr <= '0;
      rdSh   <= '0;
      rdCnt  <= '0;
      rdBit  <= 1'b0;
    end else if (str.loadRead) begin
      rdAddr <= newHdr;
      rdSh   <= mem[newHdr];
      rdCnt  <= '0;
      rdBit  <= 1'b0;
    end else if (str.shiftRead) begin
      rdBit <= rdSh[DATA_W-1];
      if (rdCnt == LAST_BIT) begin
        rdCnt  <= '0;
        rdAddr <= nextAddr;
        rdSh   <= mem[nextAddr];
      end else begin
        rdCnt <= rdCnt + BITS_W'(1);
        rdSh  <= {rdSh[DATA_W-2:0], 1'b0};
      end
    end
  end

  AST_DUMMY_LOW: assert property (@(posedge clk) disable iff (!rstN)
    str.loadRead |=> !rdBit); // R4
  AST_READ_ROLLOVER: assert property (@(posedge clk) disable iff (!rstN)
    (str.shiftRead && rdCnt == LAST_BIT && rdAddr == {ADDR_W{1'b1}}) |=> (rdAddr == '0)); // R5
  AST_ONE_STORE_OP: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({str.progWord, str.clearWord, str.progAll, str.clearAll})); // R8

endmodule

// File: rtl/ser_eeprom_slave.sv
module ser_eeprom_slave
  import ser_eeprom_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int DATA_W       = 16,
  parameter int WRITE_CYCLES = 40
) (
  input  logic clk,
  input  logic rstN,
  input  logic csIn,
  input  logic skIn,
  input  logic diIn,
  output logic doOut,
  output logic doEn
);

  strobe_t    str;
  logic [1:0] subCmd;
  logic       rdBit;

  ser_eeprom_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WRITE_CYCLES(WRITE_CYCLES)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .csIn(csIn), .skIn(skIn), .diIn(diIn),
    .subCmd(subCmd), .rdBit(rdBit), .str(str), .doOut(doOut), .doEn(doEn)
  );

  ser_eeprom_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .diIn(diIn), .str(str),
    .subCmd(subCmd), .rdBit(rdBit)
  );

endmodule

// File: tb/test_ser_eeprom_slave.sv
module test_ser_eeprom_slave;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 6;
  localparam int DW    = 16;
  localparam int WCYC  = 40;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rstN = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic doOut, doEn;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [DW-1:0] model [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_eeprom_slave #(.ADDR_W(AW), .DATA_W(DW), .WRITE_CYCLES(WCYC)) i_ser_eeprom_slave (
    .clk(clk), .rstN(rstN), .csIn(cs), .skIn(sk), .diIn(di), .doOut(doOut), .doEn(doEn)
  );

  function automatic logic [DW-1:0] pat(int a);
    return 16'(a * 32'h0AF3) ^ 16'h5C29;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(logic b);
    di = b;
    @(negedge clk); sk = 1'b1;
    idle(2); sk = 1'b0;
    idle(2);
  endtask

  task automatic csHigh();
    @(negedge clk); cs = 1'b1; idle(2);
  endtask

  task automatic csLow();
    @(negedge clk); cs = 1'b0; di = 1'b0; idle(2);
  endtask

  task automatic sendHdr(logic [1:0] op, logic [AW-1:0] addr);
    pulse(1'b1);
    pulse(op[1]); pulse(op[0]);
    for (int i = AW-1; i >= 0; i--) pulse(addr[i]);
  endtask

  task automatic writeCmd(logic [1:0] op, logic [AW-1:0] addr, logic [DW-1:0] data, int nData, int extra);
    csHigh();
    sendHdr(op, addr);
    for (int i = nData-1; i >= 0; i--) pulse(data[i]);
    for (int i = 0; i < extra; i++) pulse(1'b0);
    di = 1'b0;
  endtask

  task automatic readWords(string req, int addr, int n);
    logic [DW-1:0] word;
    check("R4", "dummy bit {en,do}", {30'd0, doEn, doOut}, 32'd2);
    for (int w = 0; w < n; w++) begin
      word = '0;
      for (int b = 0; b < DW; b++) begin
        pulse(1'b0);
        word = {word[DW-2:0], doOut};
      end
      check(req, $sformatf("word at %0d", (addr + w) % DEPTH), {16'd0, word}, {16'd0, model[(addr + w) % DEPTH]});
    end
  endtask

  task automatic readSeq(string req, int addr, int n, int dummies);
    csHigh();
    for (int i = 0; i < dummies; i++) pulse(1'b0);
    sendHdr(2'b10, AW'(addr));
    readWords(req, addr, n);
    csLow();
    check("R2", "enable after select low", {31'd0, doEn}, 32'd0);
  endtask

  task automatic finishWrite(bit timing, bit poke, bit keepHigh);
    int n = 0;
    bit rdy = 0;
    @(negedge clk); cs = 1'b0;
    while (!rdy && n < WCYC + 20) begin
      @(negedge clk); n++;
      if (n == 2) cs = 1'b1;
      else if (n >= 3) begin
        if (n == 3 && timing) check("R11", "busy level {en,do}", {30'd0, doEn, doOut}, 32'd2);
        if (doEn && doOut) rdy = 1;
        if (poke) begin
          if (n == 4) begin di = 1'b1; sk = 1'b1; end
          if (n == 6) sk = 1'b0;
          if (n == 7) di = 1'b0;
        end
      end
    end
    check("R11", "ready level seen", {31'd0, rdy}, 32'd1);
    if (timing) check("R13", "clocks to ready", n, WCYC + 1);
    if (!keepHigh) csLow();
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) model[a] = '1;
    idle(3);
    check("R1", "enable in reset", {31'd0, doEn}, 32'd0);
    rstN = 1'b1;
    idle(2);
    csHigh();
    check("R1", "enable before start bit", {31'd0, doEn}, 32'd0);
    csLow();

    // R2: activity with select low
    for (int i = 0; i < 4; i++) begin
      pulse(1'b1);
      check("R2", "enable in standby", {31'd0, doEn}, 32'd0);
    end
    di = 1'b0;

    // R3 dummy clocks, R1 erased contents
    readSeq("R3", 5, 1, 3);
    readSeq("R1", 62, 2, 0);

    // R6: write with latch clear at reset
    writeCmd(2'b01, 6'd3, 16'h1234, 16, 0);
    csLow();
    csHigh();
    check("R6", "no busy phase while disabled", {31'd0, doEn}, 32'd0);
    csLow();
    readSeq("R6", 3, 1, 0);

    // R7: enable latch (low address bits are don't-care)
    writeCmd(2'b00, 6'b11_0110, '0, 0, 0);
    csLow();

    // sweep all words; R13 / R11 measured on the first
    for (int a = 0; a < DEPTH; a++) begin
      writeCmd(2'b01, AW'(a), pat(a), DW, 0);
      model[a] = pat(a);
      finishWrite(a == 0, a == 0, 1'b0);
    end
    readSeq("R5", 60, 8, 0);
    readSeq("R4", 0, DEPTH, 2);

    // R8 erase one word
    writeCmd(2'b11, 6'd10, '0, 0, 0);
    model[10] = '1;
    finishWrite(1'b0, 1'b0, 1'b0);
    readSeq("R8", 9, 3, 0);

    // R10 wrong clock counts
    writeCmd(2'b01, 6'd20, 16'hBEEF, DW, 1);      csLow();
    writeCmd(2'b01, 6'd21, 16'hBEEF, DW - 1, 0);  csLow();
    writeCmd(2'b11, 6'd22, '0, 0, 1);             csLow();
    writeCmd(2'b00, 6'b01_0000, 16'h0000, DW, 1); csLow();
    writeCmd(2'b00, 6'b10_0000, '0, 0, 2);        csLow();
    readSeq("R10", 20, 3, 0);
    readSeq("R10", 0, 2, 0);

    // R7 disable, then every store kind is refused
    writeCmd(2'b00, 6'b00_1001, '0, 0, 0);        csLow();
    writeCmd(2'b01, 6'd30, 16'h0F0F, DW, 0);      csLow();
    writeCmd(2'b11, 6'd31, '0, 0, 0);             csLow();
    writeCmd(2'b00, 6'b10_0000, '0, 0, 0);        csLow();
    writeCmd(2'b00, 6'b01_0011, 16'h1111, DW, 0); csLow();
    readSeq("R7", 29, 4, 0);
    writeCmd(2'b00, 6'b11_0000, '0, 0, 0);        csLow();

    // R12 start bit during ready status
    writeCmd(2'b01, 6'd7, 16'h7E81, DW, 0);
    model[7] = 16'h7E81;
    finishWrite(1'b0, 1'b0, 1'b1);
    pulse(1'b1);
    check("R12", "enable after start in status", {31'd0, doEn}, 32'd0);
    pulse(1'b1); pulse(1'b0);
    for (int i = AW-1; i >= 0; i--) pulse(AW'(7) >> i);
    readWords("R12", 7, 2);
    csLow();

    // R9 fill
    writeCmd(2'b00, 6'b01_1111, 16'hC3A5, DW, 0);
    for (int a = 0; a < DEPTH; a++) model[a] = 16'hC3A5;
    finishWrite(1'b0, 1'b0, 1'b0);
    readSeq("R9", 13, DEPTH, 0);

    // R8 clear-all
    writeCmd(2'b01, 6'd40, 16'h0001, DW, 0);
    model[40] = 16'h0001;
    finishWrite(1'b0, 1'b0, 1'b0);
    writeCmd(2'b00, 6'b10_0101, '0, 0, 0);
    for (int a = 0; a < DEPTH; a++) model[a] = '1;
    finishWrite(1'b0, 1'b0, 1'b0);
    readSeq("R8", 0, DEPTH, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule